// File: doc/BRIEF.md
# Reciprocal-Table Integer Divider

This block divides one unsigned integer by another over several clock cycles and returns the quotient and the remainder. It does not retire one quotient bit per cycle. It builds the quotient from multiplications on a single shared multiplier. A caller raises `start` for one cycle with both operands. It then waits while `busy` is high and reads the results when `done` pulses.

The block picks one of three routes when it accepts a request:

- A zero divisor, or a dividend smaller than the divisor, is resolved at once.
- A divisor below the table size (1024 by default) is divided exactly with a magic constant and a shift count from a table. The quotient is the high half of the product of the dividend and that constant, adjusted and shifted. One back-multiply then gives the remainder.
- Any other divisor uses long division in 16-bit digits:
  - The divisor is normalized to its leading bit.
  - A coarse reciprocal table, indexed by the bits below that leading one, gives an underestimate of each digit.
  - The estimate is multiplied back by the divisor and subtracted.
  - Estimation repeats on the remainder until it falls below the divisor.
  - Leading quotient digits that must be zero are skipped.

Top module: `recip_div`

## Requirements
- R1: `busy` is high from the edge that accepts `start` (a non-trivial request) until the result is ready. `done` is a one-cycle pulse, and `busy` is low whenever `done` is high.
- R2: For every nonzero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor when `done` is high.
- R3: A zero divisor raises `done` and `div_by_zero` right after the accepting edge. `quotient` is all ones and `remainder` equals the dividend.
- R4: A nonzero divisor larger than the dividend completes right after the accepting edge with `quotient` zero and `remainder` equal to the dividend.
- R5: A divisor from 1 to 1023 with the dividend at least the divisor takes the exact table route. Counting the accepting edge as edge 1, `done` is high after edge 3.
- R6: A divisor of 1024 or more with the dividend at least the divisor completes by edge 60.
- R7: `start` is ignored while `busy` is high. The result belongs to the operands that were accepted.
- R8: `quotient`, `remainder` and `div_by_zero` hold their values after `done` until the next accepted `start`.
- R9: After reset, `busy`, `done` and `div_by_zero` are low, and `quotient` and `remainder` are zero.
- R10: `div_by_zero` is cleared by the next accepted request whose divisor is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled when idle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| div_by_zero | output | 1 | Last accepted divisor was zero |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
The bench builds the block with its defaults: 64-bit operands, 16-bit digits and 10-bit tables. With these values there are four quotient digits to skip or iterate, and the exact route ends at 1023. Divisors at 1023, 1024 and 1025, every power of two, and randomly sized random operands therefore exercise both table routes, the digit skip and the repeated estimate loop. Its results are compared with the language's own division and modulo, and the latency of each route is measured in edges.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SMUL,
      ST_SBACK,
      ST_LOAD,
      ST_EST,
      ST_SUB
   } div_state_e;
endpackage

// File: rtl/recip_div_mul.sv
module recip_div_mul #(
   parameter int W = 64
) (
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic [2*W-1:0] prod
);
   localparam int PW2 = 2 * W;

   assign prod = PW2'(op_a) * PW2'(op_b);
endmodule

// File: rtl/recip_div_magic_rom.sv
module recip_div_magic_rom #(
   parameter int W        = 64,
   parameter int TBL_BITS = 10,
   parameter int LG_W     = 4
) (
   input  logic [TBL_BITS-1:0] idx,
   output logic [W-1:0]        magic,
   output logic [LG_W-1:0]     lg
);
   localparam int N  = 1 << TBL_BITS;
   localparam int DW = 2 * W;

   function automatic int unsigned ceil_lg(int unsigned d);
      int unsigned l = 0;
      for (int i = 0; i <= TBL_BITS; i++)
         if ((64'(1) << i) < 64'(d)) l = i + 1;
      return l;
   endfunction

   function automatic logic [W-1:0] calc_magic(int unsigned d);
      logic [DW-1:0] pw, dd, num, q;
      if (d == 0) return '0;
      pw  = DW'(1) << ceil_lg(d);
      dd  = DW'(d);
      num = (pw - dd) << W;
      q   = num / dd + DW'(1);
      return q[W-1:0];
   endfunction

   logic [W-1:0]    m_tbl [N];
   logic [LG_W-1:0] l_tbl [N];

   for (genvar g = 0; g < N; g++) begin : g_ent
      localparam logic [W-1:0]    M = calc_magic(g);
      localparam logic [LG_W-1:0] L = LG_W'(ceil_lg(g));
      assign m_tbl[g] = M;
      assign l_tbl[g] = L;
   end

   assign magic = m_tbl[idx];
   assign lg    = l_tbl[idx];
endmodule

// File: rtl/recip_div_recip_rom.sv
module recip_div_recip_rom #(
   parameter int TBL_BITS = 10,
   parameter int DIG_W    = 16
) (
   input  logic [TBL_BITS-1:0] idx,
   output logic [DIG_W:0]      recip
);
   localparam int N  = 1 << TBL_BITS;
   localparam int K  = TBL_BITS + 1;
   localparam int EW = DIG_W + 1;

   function automatic logic [EW-1:0] calc_recip(int unsigned i);
      logic [63:0] num, den, q;
      num = 64'(1) << (K + DIG_W);
      den = (64'(1) << TBL_BITS) + 64'(i) + 64'd1;
      q   = num / den;
      return q[EW-1:0];
   endfunction

   logic [EW-1:0] r_tbl [N];

   for (genvar g = 0; g < N; g++) begin : g_ent
      localparam logic [EW-1:0] R = calc_recip(g);
      assign r_tbl[g] = R;
   end

   assign recip = r_tbl[idx];
endmodule

// File: rtl/recip_div.sv
module recip_div
   import recip_div_pkg::*;
#(
   parameter int W        = 64,
   parameter int DIG_W    = 16,
   parameter int TBL_BITS = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic         div_by_zero,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder
);
   localparam int ND    = W / DIG_W;
   localparam int IW    = (ND > 1) ? $clog2(ND) : 1;
   localparam int PW    = $clog2(W);
   localparam int K     = TBL_BITS + 1;
   localparam int RTW   = K + DIG_W;
   localparam int RW    = W + DIG_W;
   localparam int EW    = DIG_W + 1;
   localparam int LG_W  = $clog2(TBL_BITS + 1);
   localparam logic [W-1:0] SMALL_LIM = W'(1) << TBL_BITS;

   if (W % DIG_W != 0 || ND < 2) begin : g_bad_width
      $error("recip_div: W must hold at least two whole digits");
   end
   if (RTW + EW > 2 * W || RTW > 62) begin : g_bad_table
      $error("recip_div: table width too large for the multiplier");
   end

   div_state_e    state_q;
   logic [W-1:0]  n_q, d_q, quo_q;
   logic [RW-1:0] rem_q;
   logic [IW-1:0] idx_q;
   logic [EW-1:0] est_q;
   logic [PW-1:0] sft_q;
   logic          done_q, dbz_q;

   // divisor leading bit and first useful quotient digit
   logic [PW-1:0] p_in;
   logic [IW-1:0] k_in;
   logic [W-1:0]  rinit;

   always_comb begin
      p_in = '0;
      for (int i = 0; i < W; i++)
         if (divisor[i]) p_in = PW'(i);
   end

   always_comb begin
      k_in = '0;
      for (int k = 0; k < ND; k++)
         if ((dividend >> (DIG_W * k)) >= divisor) k_in = IW'(k);
      if (int'(k_in) == ND - 1) rinit = '0;
      else rinit = dividend >> (DIG_W * (int'(k_in) + 1));
   end

   // tables
   logic [W-1:0]        magic;
   logic [LG_W-1:0]     lg;
   logic [EW-1:0]       recip;
   logic [TBL_BITS-1:0] ridx;

   assign ridx = TBL_BITS'(d_q >> sft_q);

   recip_div_magic_rom #(.W(W), .TBL_BITS(TBL_BITS), .LG_W(LG_W)) i_magic (
      .idx(d_q[TBL_BITS-1:0]), .magic(magic), .lg(lg));

   recip_div_recip_rom #(.TBL_BITS(TBL_BITS), .DIG_W(DIG_W)) i_recip (
      .idx(ridx), .recip(recip));

   // shared multiplier
   logic [W-1:0]   mul_a, mul_b;
   logic [2*W-1:0] prod;
   logic [RTW-1:0] rtop;

   assign rtop = RTW'(rem_q >> sft_q);

   always_comb begin
      case (state_q)
         ST_SMUL:  begin mul_a = n_q;        mul_b = magic;     end
         ST_SBACK: begin mul_a = quo_q;      mul_b = d_q;       end
         ST_EST:   begin mul_a = W'(rtop);   mul_b = W'(recip); end
         ST_SUB:   begin mul_a = W'(est_q);  mul_b = d_q;       end
         default:  begin mul_a = '0;         mul_b = '0;        end
      endcase
   end

   recip_div_mul #(.W(W)) i_mul (.op_a(mul_a), .op_b(mul_b), .prod(prod));

   // exact small-divisor quotient from the high half
   logic [W-1:0]    mhi, mdiff, sq;
   logic [LG_W-1:0] sh2;
   logic            sh1;

   always_comb begin
      mhi   = prod[2*W-1:W];
      mdiff = n_q - mhi;
      sh1   = (lg != '0);
      sh2   = (lg == '0) ? '0 : lg - LG_W'(1);
      sq    = (mhi + (mdiff >> sh1)) >> sh2;
   end

   logic [EW-1:0]    est_raw;
   logic [DIG_W-1:0] digit;
   logic             rem_ge;

   assign est_raw = EW'(prod >> RTW);
   assign digit   = DIG_W'(n_q >> (DIG_W * int'(idx_q)));
   assign rem_ge  = (rem_q >= RW'(d_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         n_q     <= '0;
         d_q     <= '0;
         quo_q   <= '0;
         rem_q   <= '0;
         idx_q   <= '0;
         est_q   <= '0;
         sft_q   <= '0;
         done_q  <= 1'b0;
         dbz_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               n_q   <= dividend;
               d_q   <= divisor;
               dbz_q <= (divisor == '0);
               if (divisor == '0) begin
                  quo_q  <= '1;
                  rem_q  <= RW'(dividend);
                  done_q <= 1'b1;
               end else if (dividend < divisor) begin
                  quo_q  <= '0;
                  rem_q  <= RW'(dividend);
                  done_q <= 1'b1;
               end else if (divisor < SMALL_LIM) begin
                  state_q <= ST_SMUL;
               end else begin
                  sft_q   <= p_in - PW'(TBL_BITS);
                  idx_q   <= k_in;
                  rem_q   <= RW'(rinit);
                  quo_q   <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_SMUL: begin
               quo_q   <= sq;
               state_q <= ST_SBACK;
            end
            ST_SBACK: begin
               rem_q   <= RW'(n_q - W'(prod));
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_LOAD: begin
               rem_q   <= {rem_q[W-1:0], digit};
               state_q <= ST_EST;
            end
            ST_EST: begin
               if (rem_ge) begin
                  est_q   <= (est_raw == '0) ? EW'(1) : est_raw;
                  state_q <= ST_SUB;
               end else if (idx_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  idx_q   <= idx_q - IW'(1);
                  state_q <= ST_LOAD;
               end
            end
            ST_SUB: begin
               rem_q   <= rem_q - RW'(prod);
               quo_q   <= quo_q + (W'(est_q) << (DIG_W * int'(idx_q)));
               state_q <= ST_EST;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign div_by_zero = dbz_q;
   assign quotient    = quo_q;
   assign remainder   = W'(rem_q);

   // zero divisor answers on the next edge
   p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && divisor == '0) |=>
         (done && div_by_zero && !busy && quotient == '1));

   // dividend below divisor answers on the next edge
   p_early_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && divisor != '0 && dividend < divisor) |=>
         (done && !busy && quotient == '0 && remainder == $past(dividend)));

   p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |-> (remainder < d_q));

   // digit estimates never overshoot the partial remainder
   p_est_under_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUB) |-> (prod <= (2*W)'(rem_q)));

   // each new digit starts from a remainder below the divisor
   p_load_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD) |-> (rem_q < RW'(d_q)));
endmodule

// File: tb/test_recip_div.sv
module test_recip_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] dividend = '0;
   logic [63:0] divisor = '0;
   logic        busy, done, div_by_zero;
   logic [63:0] quotient, remainder;

   int checks = 0;
   int fails  = 0;
   logic busy_seen;

   always #10 clk = ~clk;

   recip_div i_recip_div (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .div_by_zero(div_by_zero),
      .quotient(quotient), .remainder(remainder));

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drives one request, returns the edge count until done
   task automatic run_div(input logic [63:0] n, input logic [63:0] d, output int cyc);
      @(negedge clk);
      start = 1'b1; dividend = n; divisor = d;
      @(posedge clk);
      cyc = 1;
      @(negedge clk);
      start = 1'b0;
      busy_seen = busy;
      while (!done && cyc < 200) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic check_result(input logic [63:0] n, input logic [63:0] d, input string req);
      if (d == 0) begin
         check(req, "quotient", quotient, '1);
         check(req, "remainder", remainder, n);
         check(req, "div_by_zero", 64'(div_by_zero), 64'd1);
      end else begin
         check(req, "quotient", quotient, n / d);
         check(req, "remainder", remainder, n % d);
         check(req, "div_by_zero", 64'(div_by_zero), 64'd0);
      end
   endtask

   // full check of one divide including route latency
   task automatic divide(input logic [63:0] n, input logic [63:0] d);
      int cyc;
      run_div(n, d, cyc);
      check("R2", "done seen", 64'(done), 64'd1);
      check_result(n, d, (d == 0) ? "R3" : "R2");
      if (d == 0) check("R3", "latency", 64'(cyc), 64'd1);
      else if (n < d) check("R4", "latency", 64'(cyc), 64'd1);
      else if (d < 64'd1024) begin
         check("R5", "latency", 64'(cyc), 64'd3);
         check("R1", "busy after accept", 64'(busy_seen), 64'd1);
      end else begin
         check("R6", "latency within 60", 64'(cyc <= 60), 64'd1);
         check("R1", "busy after accept", 64'(busy_seen), 64'd1);
      end
      check("R1", "busy low with done", 64'(busy), 64'd0);
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [63:0] q0, r0;
      int cyc;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R9", "busy", 64'(busy), 64'd0);
      check("R9", "done", 64'(done), 64'd0);
      check("R9", "div_by_zero", 64'(div_by_zero), 64'd0);
      check("R9", "quotient", quotient, 64'd0);
      check("R9", "remainder", remainder, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 zero divisor, then R10 clearing of the flag
      divide(64'd12345, 64'd0);
      divide(64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      divide(64'd1000, 64'd7);
      check("R10", "flag cleared", 64'(div_by_zero), 64'd0);

      // R4 dividend below divisor
      divide(64'd5, 64'd9);
      divide(64'd0, 64'd3000);
      divide(64'h0000_FFFF_0000_0000, 64'h8000_0000_0000_0000);

      // R5 small divisors and the threshold
      divide(rnd64(), 64'd1);
      divide(rnd64(), 64'd2);
      divide(rnd64(), 64'd3);
      divide(64'hFFFF_FFFF_FFFF_FFFF, 64'd7);
      divide(64'hFFFF_FFFF_FFFF_FFFF, 64'd1000);
      divide(rnd64(), 64'd1023);
      divide(64'hFFFF_FFFF_FFFF_FFFF, 64'd1023);
      divide(rnd64(), 64'd1024);
      divide(64'hFFFF_FFFF_FFFF_FFFF, 64'd1025);
      divide(64'd1023, 64'd1023);
      divide(64'd1024, 64'd1024);

      // powers of two, R5 and R6
      for (int k = 0; k < 64; k++) divide(rnd64(), 64'd1 << k);

      // R2 random operands of random sizes
      for (int i = 0; i < 300; i++) begin
         logic [63:0] n, d;
         n = rnd64() >> $urandom_range(0, 40);
         d = rnd64() >> $urandom_range(0, 63);
         if (d == 0) d = 64'd1;
         divide(n, d);
      end
      for (int i = 0; i < 40; i++) begin
         logic [63:0] d;
         d = rnd64() >> $urandom_range(1, 10);
         divide(d + (rnd64() % d), d);
      end

      // R7 start while busy is ignored
      @(negedge clk);
      start = 1'b1; dividend = 64'hDEAD_BEEF_1234_5678; divisor = 64'h0000_0123_4567_89AB;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start = 1'b1; dividend = 64'd99; divisor = 64'd0;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 200) begin @(posedge clk); cyc++; @(negedge clk); end
      check("R7", "quotient", quotient, 64'hDEAD_BEEF_1234_5678 / 64'h0000_0123_4567_89AB);
      check("R7", "remainder", remainder, 64'hDEAD_BEEF_1234_5678 % 64'h0000_0123_4567_89AB);
      check("R7", "div_by_zero", 64'(div_by_zero), 64'd0);

      // R8 hold and R1 single-cycle done
      divide(64'h7777_6666_5555_4444, 64'h0000_0000_0001_2345);
      q0 = quotient;
      r0 = remainder;
      @(negedge clk);
      check("R1", "done pulse", 64'(done), 64'd0);
      repeat (3) @(negedge clk);
      check("R8", "quotient held", quotient, q0);
      check("R8", "remainder held", remainder, r0);
      check("R8", "flag held", 64'(div_by_zero), 64'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule